// File: doc/BRIEF.md
# AXI Incrementing-Pattern Memory Filler

This block fills a region of external memory with a known pattern. Software programs a byte base address through a small AXI4-Lite register slave and then sets a start bit. The block then writes a fixed number of 32-bit words over an AXI4 master write port, with word i holding the value i, and raises a done status bit that software polls.

The base register is copied into the write engine at the moment a start is accepted. Each run therefore targets the address programmed most recently. A value written earlier is never reused, and a base written while a run is active does not disturb that run. The transfer is cut into INCR bursts of up to a parameterised number of beats, and no burst crosses a 4 KB page. Only one burst is in flight at a time. A non-OKAY write response is kept as a sticky error flag until the next start.

Top module: `pattern_fill_engine`

## Requirements
- R1: After reset the control/status register at offset 0x00 reads 0x4 (idle set, done clear, error clear), and the base register at offset 0x10 reads 0.
- R2: The base register at offset 0x10 is writable and reads back the value written, with bits [1:0] always reading zero.
- R3: Writing 1 to bit 0 of offset 0x00 while idle starts a run. The run writes WORDS (default 50) words, and word i carries the value i at byte address base + 4*i. Every beat has WSTRB all ones, AWSIZE 4 bytes and AWBURST INCR (2'b01).
- R4: When a run starts after the base has been moved (for example by 0x10), the run writes at the new base, and words at the previous base outside the new region keep their contents.
- R5: A write to the base register during a run does not change the addresses of that run, but the new value is stored and read back. A start written while the block is busy is ignored.
- R6: Each burst has at most MAX_BURST (default 16) beats and never crosses a 4 KB boundary. WLAST is high exactly on the final beat of each burst.
- R7: Status bits at offset 0x00 are: bit 0 reads 0, bit 1 done, bit 2 idle, bit 3 error. During a run, idle and done read 0. Done is set only after the last write response has been accepted. An accepted start clears both done and error.
- R8: A non-OKAY write response sets the error bit, which stays set until the next start. The run still writes all of its words and ends with done set.
- R9: While AWVALID or WVALID waits for its ready, it stays high, and the address, length, data and WLAST stay unchanged.
- R10: A new write address is issued only after the previous burst's data is complete and its write response has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 5 | Register write address |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Register write byte strobes |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_bresp | output | 2 | Register write response (always OKAY) |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_araddr | input | 5 | Register read address |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response (always OKAY) |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| m_awaddr | output | 32 | Memory write burst byte address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size (2 = 4 bytes) |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Pattern data word |
| m_wstrb | output | 4 | Byte strobes (all ones) |
| m_wlast | output | 1 | Final beat of the burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The bench moves the base by 0x10 between runs and clears memory before each run. A design that keeps an old address would leave the new region unwritten and overwrite the old one. A base rewrite and a second start are issued in the middle of a run: a block that reads the live register would scatter words, and one that accepts the restart would write too many beats. A base six words below a 4 KB page must give a first burst of six beats; a design that does not clip the length would cross the page. The bench also injects an error response on the second burst and stalls both channels. These catch a lost or non-sticky error flag, a done raised before the last response, and changes in AW or W payload while the slave holds ready low.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int REG_AW     = 5;
    localparam int PAGE_BYTES = 4096;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [2:0] SIZE_WORD  = 3'b010;

    localparam logic [REG_AW-1:0] CTRL_OFF = 5'h00;
    localparam logic [REG_AW-1:0] BASE_OFF = 5'h10;

    localparam int CTRL_GO   = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_IDLE = 2;
    localparam int STAT_ERR  = 3;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        len;
    } aw_cmd_t;

    typedef struct packed {
        logic err;
        logic idle;
        logic done;
    } stat_t;

    // beats that remain before the next 4 KB page
    function automatic logic [31:0] beats_to_page(input logic [ADDR_W-1:0] addr);
        return (32'(PAGE_BYTES) - {20'b0, addr[11:0]}) >> 2;
    endfunction

    // beats in the next burst: smallest of cap, remaining words, room in page
    function automatic logic [31:0] burst_beats(input logic [ADDR_W-1:0] addr,
                                                input logic [31:0] remaining,
                                                input logic [31:0] cap);
        logic [31:0] n;
        n = cap;
        if (remaining < n) n = remaining;
        if (beats_to_page(addr) < n) n = beats_to_page(addr);
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STAT_DONE] = s.done;
        w[STAT_IDLE] = s.idle;
        w[STAT_ERR]  = s.err;
        return w;
    endfunction

endpackage

// File: rtl/pfe_regs.sv
module pfe_regs
    import pfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_AW-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [STRB_W-1:0]    s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [REG_AW-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    input  logic                 busy_i,
    input  logic                 done_i,
    input  logic                 err_i,
    output logic                 start_o,
    output logic [ADDR_W-1:0]    base_o
);

    logic              bvalid_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ADDR_W-1:0] base_q;
    logic              done_q;
    logic              err_q;
    logic              wr_fire;
    logic              rd_fire;
    stat_t             stat;

    assign wr_fire   = s_awvalid && s_wvalid && !bvalid_q;
    assign rd_fire   = s_arvalid && !rvalid_q;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_arready = !rvalid_q;
    assign s_bvalid  = bvalid_q;
    assign s_bresp   = RESP_OKAY;
    assign s_rvalid  = rvalid_q;
    assign s_rresp   = RESP_OKAY;
    assign s_rdata   = rdata_q;
    assign base_o    = base_q;

    assign start_o = wr_fire && (s_awaddr == CTRL_OFF) && s_wstrb[0]
                     && s_wdata[CTRL_GO] && !busy_i;

    always_comb begin
        stat.err  = err_q;
        stat.idle = !busy_i;
        stat.done = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid_q <= 1'b0;
            base_q   <= '0;
        end else begin
            if (wr_fire) begin
                bvalid_q <= 1'b1;
            end else if (s_bready) begin
                bvalid_q <= 1'b0;
            end
            if (wr_fire && (s_awaddr == BASE_OFF)) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (s_wstrb[b]) base_q[8*b +: 8] <= s_wdata[8*b +: 8];
                end
                base_q[1:0] <= 2'b00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_o)     done_q <= 1'b0;
            else if (done_i) done_q <= 1'b1;
            if (start_o)     err_q  <= 1'b0;
            else if (err_i)  err_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            if (s_araddr == CTRL_OFF)      rdata_q <= pack_status(stat);
            else if (s_araddr == BASE_OFF) rdata_q <= base_q;
            else                           rdata_q <= '0;
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_i);

    // R3
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> busy_i);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !start_o) |=> err_q);

endmodule

// File: rtl/pfe_writer.sv
module pfe_writer
    import pfe_pkg::*;
#(
    parameter int WORDS     = 50,
    parameter int MAX_BURST = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    base_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [ADDR_W-1:0]    m_awaddr,
    output logic [7:0]           m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [DATA_W-1:0]    m_wdata,
    output logic [STRB_W-1:0]    m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic [1:0]           m_bresp,
    input  logic                 m_bvalid,
    output logic                 m_bready
);

    localparam int CNT_W  = $clog2(WORDS + 1);
    localparam int BEAT_W = $clog2(MAX_BURST + 1);

    wr_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] word_q;
    logic [CNT_W-1:0]  rem_q;
    logic [BEAT_W-1:0] beats_q;
    aw_cmd_t           cmd;

    always_comb begin
        cmd.addr = addr_q;
        cmd.len  = 8'(burst_beats(addr_q, 32'(rem_q), 32'(MAX_BURST)) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            addr_q  <= '0;
            word_q  <= '0;
            rem_q   <= '0;
            beats_q <= '0;
        end else begin
            case (state_q)
                WR_IDLE: if (start_i) begin
                    addr_q  <= base_i & ~ADDR_W'(3);
                    word_q  <= '0;
                    rem_q   <= CNT_W'(WORDS);
                    state_q <= WR_ADDR;
                end
                WR_ADDR: if (m_awready) begin
                    beats_q <= BEAT_W'(32'(cmd.len) + 32'd1);
                    state_q <= WR_DATA;
                end
                WR_DATA: if (m_wready) begin
                    word_q  <= word_q + DATA_W'(1);
                    addr_q  <= addr_q + ADDR_W'(4);
                    rem_q   <= rem_q - CNT_W'(1);
                    beats_q <= beats_q - BEAT_W'(1);
                    if (beats_q == BEAT_W'(1)) state_q <= WR_RESP;
                end
                WR_RESP: if (m_bvalid) begin
                    state_q <= (rem_q == '0) ? WR_IDLE : WR_ADDR;
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    assign m_awvalid = (state_q == WR_ADDR);
    assign m_awaddr  = cmd.addr;
    assign m_awlen   = cmd.len;
    assign m_awsize  = SIZE_WORD;
    assign m_awburst = BURST_INCR;
    assign m_wvalid  = (state_q == WR_DATA);
    assign m_wdata   = word_q;
    assign m_wstrb   = '1;
    assign m_wlast   = (beats_q == BEAT_W'(1));
    assign m_bready  = (state_q == WR_RESP);
    assign busy_o    = (state_q != WR_IDLE);
    assign done_o    = m_bready && m_bvalid && (rem_q == '0);
    assign err_o     = m_bready && m_bvalid && (m_bresp != RESP_OKAY);

    // shadow tracking of the bus, used only by the checks below
    logic [8:0] sh_left;
    logic       sh_bpend;
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_left  <= '0;
            sh_bpend <= 1'b0;
        end else begin
            if (m_awvalid && m_awready)     sh_left <= 9'(m_awlen) + 9'd1;
            else if (m_wvalid && m_wready)  sh_left <= sh_left - 9'd1;
            if (m_wvalid && m_wready && m_wlast) sh_bpend <= 1'b1;
            else if (m_bvalid && m_bready)       sh_bpend <= 1'b0;
        end
    end

    // R6
    wlast_final_chk: assert property (@(posedge clk) disable iff (rst)
        m_wvalid |-> (m_wlast == (sh_left == 9'd1)));

    // R6
    page_len_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid |-> ((32'(m_awlen) < 32'(MAX_BURST)) &&
                       ({20'b0, m_awaddr[11:0]} + (32'(m_awlen) + 32'd1) * 32'd4 <= 32'(PAGE_BYTES))));

    // R10
    one_burst_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid |-> (!sh_bpend && sh_left == 9'd0));

    // R9
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));

    // R9
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

endmodule

// File: rtl/pattern_fill_engine.sv
module pattern_fill_engine
    import pfe_pkg::*;
#(
    parameter int WORDS     = 50,
    parameter int MAX_BURST = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_AW-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [STRB_W-1:0]    s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [REG_AW-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    output logic [ADDR_W-1:0]    m_awaddr,
    output logic [7:0]           m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [DATA_W-1:0]    m_wdata,
    output logic [STRB_W-1:0]    m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic [1:0]           m_bresp,
    input  logic                 m_bvalid,
    output logic                 m_bready
);

    logic              start;
    logic              busy;
    logic              done;
    logic              err;
    logic [ADDR_W-1:0] base;

    pfe_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .busy_i    (busy),
        .done_i    (done),
        .err_i     (err),
        .start_o   (start),
        .base_o    (base)
    );

    pfe_writer #(
        .WORDS     (WORDS),
        .MAX_BURST (MAX_BURST)
    ) u_writer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .base_i    (base),
        .busy_o    (busy),
        .done_o    (done),
        .err_o     (err),
        .m_awaddr  (m_awaddr),
        .m_awlen   (m_awlen),
        .m_awsize  (m_awsize),
        .m_awburst (m_awburst),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_wlast   (m_wlast),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_bresp   (m_bresp),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready)
    );

endmodule

// File: tb/sim_pattern_fill_engine.sv
`timescale 1ns/1ps
module sim_pattern_fill_engine;

    localparam int NW = 50;
    localparam logic [31:0] SENT = 32'hA5A5_A5A5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0, s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = 4'hF;
    logic        s_wvalid = 1'b0, s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b1;
    logic [4:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0, s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b1;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awvalid, m_awready;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_wlast, m_wvalid, m_wready;
    logic [1:0]  m_bresp;
    logic        m_bvalid, m_bready;

    pattern_fill_engine u0 (.*);

    // ---------------- memory slave model ----------------
    logic [31:0] mem [0:2047];
    logic        mem_clr = 1'b0, log_clr = 1'b0, stall_en = 1'b0;
    int          err_burst = -1;
    logic        in_burst;
    logic [31:0] cur;
    int          left, cyc;
    int          burst_cnt, beat_cnt, first_len, max_len;
    int          cross_viol, wlast_viol, overlap_viol, fmt_viol;
    logic        bv;
    logic [1:0]  br;

    assign m_awready = !in_burst && !bv && (!stall_en || cyc[1]);
    assign m_wready  = in_burst && (!stall_en || cyc[0]);
    assign m_bvalid  = bv;
    assign m_bresp   = br;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            in_burst <= 1'b0; bv <= 1'b0; br <= 2'b00; cur <= '0; left <= 0; cyc <= 0;
            burst_cnt <= 0; beat_cnt <= 0; first_len <= 0; max_len <= 0;
            cross_viol <= 0; wlast_viol <= 0; overlap_viol <= 0; fmt_viol <= 0;
        end else begin
            if (log_clr) begin
                burst_cnt <= 0; beat_cnt <= 0; first_len <= 0; max_len <= 0;
                cross_viol <= 0; wlast_viol <= 0; overlap_viol <= 0; fmt_viol <= 0;
            end
            if (mem_clr) for (int k = 0; k < 2048; k++) mem[k] <= SENT;
            if (m_awvalid && (in_burst || bv)) overlap_viol <= overlap_viol + 1;
            if (m_awvalid && m_awready) begin
                cur <= m_awaddr; left <= int'(m_awlen) + 1; in_burst <= 1'b1;
                burst_cnt <= burst_cnt + 1;
                if (burst_cnt == 0) first_len <= int'(m_awlen) + 1;
                if (int'(m_awlen) + 1 > max_len) max_len <= int'(m_awlen) + 1;
                if (int'(m_awaddr[11:0]) + (int'(m_awlen) + 1) * 4 > 4096) cross_viol <= cross_viol + 1;
                if (m_awburst != 2'b01 || m_awsize != 3'b010) fmt_viol <= fmt_viol + 1;
            end
            if (m_wvalid && m_wready) begin
                mem[cur[12:2]] <= m_wdata;
                cur <= cur + 4; left <= left - 1; beat_cnt <= beat_cnt + 1;
                if (m_wstrb != 4'hF) fmt_viol <= fmt_viol + 1;
                if (m_wlast != (left == 1)) wlast_viol <= wlast_viol + 1;
                if (left == 1) begin
                    in_burst <= 1'b0; bv <= 1'b1;
                    br <= (burst_cnt == err_burst + 1) ? 2'b10 : 2'b00;
                end
            end
            if (bv && m_bready) bv <= 1'b0;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic lite_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic lite_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_arvalid = 1'b0;
        d = s_rdata;
    endtask

    task automatic clear_all();
        @(negedge clk); mem_clr = 1'b1; log_clr = 1'b1;
        @(negedge clk); mem_clr = 1'b0; log_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        int n = 0;
        do begin lite_rd(5'h00, v); n++; end while (!v[1] && n < 4000);
        chk(v[1] == 1'b1, req, "done bit after run", v, 32'h6);
    endtask

    task automatic chk_fill(input logic [31:0] base, input string req);
        int bad = 0;
        logic [31:0] got = '0;
        for (int i = 0; i < NW; i++) begin
            if (mem[(base >> 2) + i] != 32'(i)) begin
                if (bad == 0) got = mem[(base >> 2) + i];
                bad++;
            end
        end
        chk(bad == 0, req, "pattern words at base (first mismatch)", got, 32'(0));
        chk(mem[(base >> 2) + NW] == SENT, req, "word after region untouched",
            mem[(base >> 2) + NW], SENT);
    endtask

    task automatic run_at(input logic [31:0] base);
        clear_all();
        lite_wr(5'h10, base);
        lite_wr(5'h00, 32'h1);
        wait_done("R7");
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        lite_rd(5'h00, v); chk(v == 32'h4, "R1", "status after reset", v, 32'h4);
        lite_rd(5'h10, v); chk(v == 32'h0, "R1", "base after reset", v, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        run_at(32'h100);
        lite_rd(5'h10, v); chk(v == 32'h100, "R2", "base readback", v, 32'h100);
        chk_fill(32'h100, "R3");
        chk(beat_cnt == NW, "R3", "beats written", beat_cnt, NW);
        chk(fmt_viol == 0, "R3", "strobe/size/burst violations", fmt_viol, 0);
        chk(burst_cnt == 4, "R6", "burst count from 0x100", burst_cnt, 4);
        chk(max_len <= 16, "R6", "longest burst", max_len, 16);
        chk(wlast_viol == 0, "R6", "WLAST misplacements", wlast_viol, 0);
        lite_rd(5'h00, v); chk(v == 32'h6, "R7", "status after run", v, 32'h6);
    endtask

    task automatic t_rebase();
        run_at(32'h110);
        chk_fill(32'h110, "R4");
        chk(mem[32'h100 >> 2] == SENT, "R4", "old base word untouched", mem[32'h100 >> 2], SENT);
        run_at(32'h120);
        chk_fill(32'h120, "R4");
        chk(mem[32'h110 >> 2] == SENT, "R4", "previous base word untouched", mem[32'h110 >> 2], SENT);
    endtask

    task automatic t_boundary();
        run_at(32'hFE8);
        chk_fill(32'hFE8, "R3");
        chk(first_len == 6, "R6", "first burst clipped at page", first_len, 6);
        chk(burst_cnt == 4, "R6", "bursts across page", burst_cnt, 4);
        chk(cross_viol == 0, "R6", "page crossings", cross_viol, 0);
    endtask

    task automatic t_midrun();
        logic [31:0] v;
        clear_all();
        lite_wr(5'h10, 32'h300);
        lite_wr(5'h00, 32'h1);
        lite_rd(5'h00, v); chk(v == 32'h0, "R7", "status while running", v, 32'h0);
        lite_wr(5'h10, 32'h600);
        lite_wr(5'h00, 32'h1);
        wait_done("R5");
        chk_fill(32'h300, "R5");
        chk(mem[32'h600 >> 2] == SENT, "R5", "late base not written", mem[32'h600 >> 2], SENT);
        chk(beat_cnt == NW, "R5", "busy start ignored (beats)", beat_cnt, NW);
        lite_rd(5'h10, v); chk(v == 32'h600, "R5", "late base stored", v, 32'h600);
    endtask

    task automatic t_error();
        logic [31:0] v;
        err_burst = 1;
        run_at(32'h100);
        err_burst = -1;
        lite_rd(5'h00, v); chk(v == 32'hE, "R8", "error, done, idle set", v, 32'hE);
        chk_fill(32'h100, "R8");
        lite_rd(5'h00, v); chk(v[3] == 1'b1, "R8", "error still set", v, 32'hE);
        run_at(32'h200);
        lite_rd(5'h00, v); chk(v == 32'h6, "R7", "error cleared by start", v, 32'h6);
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        run_at(32'h1100);
        stall_en = 1'b0;
        chk_fill(32'h1100, "R9");
        chk(wlast_viol == 0, "R9", "WLAST under stalls", wlast_viol, 0);
        chk(overlap_viol == 0, "R10", "AW issued before B", overlap_viol, 0);
    endtask

    task automatic t_align();
        logic [31:0] v;
        lite_wr(5'h10, 32'h203);
        lite_rd(5'h10, v); chk(v == 32'h200, "R2", "low bits read zero", v, 32'h200);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_rebase();
        t_boundary();
        t_midrun();
        t_error();
        t_stall();
        t_align();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule